// File: doc/BRIEF.md
# Vectored Interrupt Controller

This controller folds up to 32 level-sensitive request lines into a single interrupt output for a processor. Software enables each request line with one bit of an enable register, and binds lines to a set of 16 prioritised vector slots. Each slot holds a control word, which carries a slot enable and a source number, and a handler address. When an enabled source that an enabled slot names is active, the controller raises its interrupt output. On reading the vector register, software gets the handler address of the winning slot.

That read claims the interrupt. The controller latches the address it returned and drops its output. It stays quiet until software writes any value to the vector register to mark the end of service. An enabled active source that no enabled slot names yields a programmable fallback address instead. Service is not nested: only one claim can be outstanding at a time.

All registers sit behind a simple word-addressed read/write bus. Writes take effect at the clock edge. Read data is returned in the same cycle as the strobe.

Top module: `vectored_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, so every source and slot is disabled and `irq_o` is low.
- R2: The source enable register at word 0 is fully readable and writable. Bit n gates request line n, and a line whose bit is 0 never raises `irq_o` or wins a slot.
- R3: Slot i's control word is at word 16+i. Bit 5 is the slot enable and bits 4:0 name the source, so 0x20|n binds source n. Bits above 5 are dropped and read zero. A slot with bit 5 clear is never selected.
- R4: Slot i's handler address is at word 32+i and the fallback address is at word 2. Both are full-width and read back as written.
- R5: Whenever no claim is outstanding, `irq_o` is high in the same cycle that any source is both active and enabled, and low otherwise.
- R6: A read of word 1 with no claim outstanding returns the handler address of the selected slot. If no enabled slot names an enabled active source, it returns the fallback address.
- R7: When several enabled slots have enabled active sources, the slot with the lowest index is selected.
- R8: A read of word 1 while `irq_o` is high starts a claim. During the claim `irq_o` stays low, and reads of word 1 return the latched address regardless of source or configuration changes.
- R9: Any write to word 1 ends an outstanding claim, and `irq_o` again follows R5 from the next cycle. A write to word 1 with no claim outstanding changes nothing.
- R10: A read of word 1 while `irq_o` is low does not start a claim.
- R11: Word addresses with no register read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NSRC | Level request lines, active high |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request to the processor, active high |

## Verification
The bench first claims an interrupt and then, while the claim is open, raises a higher-priority source and reprograms its slot. A controller that did not latch the address would return the new handler, and one that did not mask the output would re-raise `irq_o` before the acknowledge. The bench also covers these cases:
- A slot whose enable bit is clear but whose source number matches. A design that decoded only the source field would return that slot's handler instead of the next slot's.
- An enabled source with no enabled slot. A design would fail here by returning zero or a stale handler instead of the fallback address.
- A read of the vector while nothing is pending. This must not claim, and a design that claimed anyway would block the next interrupt.
- An acknowledge write while idle. This must leave everything unchanged.

A long random phase mixes configuration writes, request changes, claims and acknowledges against a bench model of the whole register state.

// File: rtl/virq_pkg.sv
// Shared constants and types for the vectored interrupt controller.
// Assumes a 6-bit word address space and at most 32 request lines.
package virq_pkg;
    localparam int unsigned ADDR_W      = 6;
    localparam int unsigned CTRL_SRC_W  = 5;               // source number field width
    localparam int unsigned CTRL_EN_BIT = CTRL_SRC_W;      // slot enable sits above the source field
    localparam int unsigned CTRL_W      = CTRL_SRC_W + 1;
    localparam int unsigned SRC_SPACE   = 1 << CTRL_SRC_W;

    localparam logic [ADDR_W-1:0] OFS_ENABLE    = 6'd0;
    localparam logic [ADDR_W-1:0] OFS_VECTOR    = 6'd1;
    localparam logic [ADDR_W-1:0] OFS_FALLBACK  = 6'd2;
    localparam logic [ADDR_W-1:0] OFS_SLOT_CTRL = 6'd16;
    localparam logic [ADDR_W-1:0] OFS_SLOT_ADDR = 6'd32;

    typedef struct packed {
        logic                  en;
        logic [CTRL_SRC_W-1:0] src;
    } slot_ctrl_t;
endpackage

// File: rtl/virq_regfile.sv
// Register file: source enables, fallback address, slot control words and
// slot handler addresses, plus the read-data multiplexer.
// Assumes NSRC <= DW, NSRC <= 32 and NSLOT <= 16 (slot windows are 16 words).
module virq_regfile
    import virq_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned DW    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DW-1:0]                 bus_wdata,
    input  logic [DW-1:0]                 vec_value,
    output logic [DW-1:0]                 bus_rdata,
    output logic [NSRC-1:0]               src_en,
    output logic [DW-1:0]                 fallback,
    output slot_ctrl_t [NSLOT-1:0]        slot_ctrl,
    output logic [NSLOT-1:0][DW-1:0]      slot_addr
);
    logic wr_strobe;
    assign wr_strobe = bus_sel && bus_wr;

    // Global registers: enable mask and fallback address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en   <= '0;
            fallback <= '0;
        end else if (wr_strobe) begin
            if (bus_addr == OFS_ENABLE)   src_en   <= bus_wdata[NSRC-1:0];
            if (bus_addr == OFS_FALLBACK) fallback <= bus_wdata;
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic hit_ctrl, hit_addr;
        assign hit_ctrl = wr_strobe && (bus_addr == OFS_SLOT_CTRL + ADDR_W'(s));
        assign hit_addr = wr_strobe && (bus_addr == OFS_SLOT_ADDR + ADDR_W'(s));

        // Per-slot storage: control word keeps only enable and source fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_ctrl[s] <= '0;
                slot_addr[s] <= '0;
            end else begin
                if (hit_ctrl) slot_ctrl[s] <= slot_ctrl_t'(bus_wdata[CTRL_W-1:0]);
                if (hit_addr) slot_addr[s] <= bus_wdata;
            end
        end
    end

    // Read multiplexer; unmapped words return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_ENABLE)   bus_rdata[NSRC-1:0] = src_en;
        if (bus_addr == OFS_VECTOR)   bus_rdata = vec_value;
        if (bus_addr == OFS_FALLBACK) bus_rdata = fallback;
        for (int s = 0; s < NSLOT; s++) begin
            if (bus_addr == OFS_SLOT_CTRL + ADDR_W'(s)) bus_rdata[CTRL_W-1:0] = slot_ctrl[s];
            if (bus_addr == OFS_SLOT_ADDR + ADDR_W'(s)) bus_rdata = slot_addr[s];
        end
    end

    // R2
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && bus_addr == OFS_ENABLE) |=> (src_en == $past(bus_wdata[NSRC-1:0])));

    // R4
    fallback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && bus_addr == OFS_FALLBACK) |=> $stable(fallback));
endmodule

// File: rtl/virq_arbiter.sv
// Combinational slot selection: masks the request lines with their enables,
// finds every enabled slot whose source is active and picks the lowest index.
// Falls back to the fallback address when no slot matches.
module virq_arbiter
    import virq_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned DW    = 32
) (
    input  logic [NSRC-1:0]          src_i,
    input  logic [NSRC-1:0]          src_en,
    input  logic [DW-1:0]            fallback,
    input  slot_ctrl_t [NSLOT-1:0]   slot_ctrl,
    input  logic [NSLOT-1:0][DW-1:0] slot_addr,
    output logic                     any_active,
    output logic [DW-1:0]            live_addr
);
    logic [SRC_SPACE-1:0] active_ext;
    logic [NSLOT-1:0]     slot_hit;
    logic [NSLOT-1:0]     grant;

    assign active_ext = SRC_SPACE'(src_i & src_en);
    assign any_active = |active_ext;

    for (genvar s = 0; s < NSLOT; s++) begin : g_hit
        assign slot_hit[s] = slot_ctrl[s].en && active_ext[slot_ctrl[s].src];
    end

    // Priority pick: scan downward so the lowest hitting index is kept.
    always_comb begin
        grant     = '0;
        live_addr = fallback;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                grant     = '0;
                grant[s]  = 1'b1;
                live_addr = slot_addr[s];
            end
        end
    end

    // Grant checks, evaluated whenever the selection changes.
    always_comb begin
        // R7
        grant_onehot_chk: assert ($onehot0(grant));
        // R6
        grant_cover_chk: assert (!(|slot_hit) || (|grant));
    end
endmodule

// File: rtl/virq_service.sv
// Claim tracking: a vector read while the output is up latches the address
// and masks the output; any vector write ends the claim. No nesting.
module virq_service #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vec_rd,
    input  logic          vec_wr,
    input  logic          any_active,
    input  logic [DW-1:0] live_addr,
    output logic          irq_o,
    output logic [DW-1:0] vec_value
);
    logic          claimed_q;
    logic [DW-1:0] vec_q;

    assign irq_o     = any_active && !claimed_q;
    assign vec_value = claimed_q ? vec_q : live_addr;

    // Claim state: acknowledge has priority over a new claim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claimed_q <= 1'b0;
            vec_q     <= '0;
        end else if (vec_wr) begin
            claimed_q <= 1'b0;
        end else if (vec_rd && irq_o) begin
            claimed_q <= 1'b1;
            vec_q     <= live_addr;
        end
    end

    // R8
    claim_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claimed_q) |-> $past(vec_rd && any_active));

    // R8
    vector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claimed_q && $past(claimed_q)) |-> $stable(vec_q));

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_wr |=> !claimed_q);

    // R10
    no_idle_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!claimed_q && !any_active) |=> !claimed_q);
endmodule

// File: rtl/vectored_irq_ctrl.sv
// Top level: request lines, register bus and interrupt output.
// Assumes single-cycle bus strobes; read data is combinational.
module vectored_irq_ctrl
    import virq_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o
);
    logic [NSRC-1:0]          src_en;
    logic [DW-1:0]            fallback;
    slot_ctrl_t [NSLOT-1:0]   slot_ctrl;
    logic [NSLOT-1:0][DW-1:0] slot_addr;
    logic                     any_active;
    logic [DW-1:0]            live_addr;
    logic [DW-1:0]            vec_value;
    logic                     vec_rd, vec_wr;

    assign vec_rd = bus_sel && !bus_wr && (bus_addr == OFS_VECTOR);
    assign vec_wr = bus_sel &&  bus_wr && (bus_addr == OFS_VECTOR);

    virq_regfile #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .vec_value(vec_value),
        .bus_rdata(bus_rdata), .src_en(src_en), .fallback(fallback),
        .slot_ctrl(slot_ctrl), .slot_addr(slot_addr)
    );

    virq_arbiter #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_arb (
        .src_i(src_i), .src_en(src_en), .fallback(fallback),
        .slot_ctrl(slot_ctrl), .slot_addr(slot_addr),
        .any_active(any_active), .live_addr(live_addr)
    );

    virq_service #(.DW(DW)) u_svc (
        .clk(clk), .rst_n(rst_n), .vec_rd(vec_rd), .vec_wr(vec_wr),
        .any_active(any_active), .live_addr(live_addr),
        .irq_o(irq_o), .vec_value(vec_value)
    );

    // R5
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(src_i & src_en)));
endmodule

// File: tb/vectored_irq_ctrl_bench.sv
module vectored_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;
    localparam int NSLOT = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_i;
    logic        bus_sel, bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the register state
    logic [31:0] en_m, fb_m, vec_m;
    logic [5:0]  ctrl_m [NSLOT];
    logic [31:0] hnd_m  [NSLOT];
    bit          claim_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    vectored_irq_ctrl u_vectored_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] live_model();
        for (int s = 0; s < NSLOT; s++)
            if (ctrl_m[s][5] && src_i[ctrl_m[s][4:0]] && en_m[ctrl_m[s][4:0]])
                return hnd_m[s];
        return fb_m;
    endfunction

    function automatic logic irq_model();
        return (|(src_i & en_m)) && !claim_m;
    endfunction

    function automatic logic [31:0] reg_model(input logic [5:0] a);
        if (a == 6'd0) return en_m;
        if (a == 6'd1) return claim_m ? vec_m : live_model();
        if (a == 6'd2) return fb_m;
        if (a >= 6'd16 && a < 6'd32) return {26'd0, ctrl_m[a-6'd16]};
        if (a >= 6'd32 && a < 6'd48) return hnd_m[a-6'd32];
        return 32'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_irq(input string req);
        #1 chk(req, {31'd0, irq_o}, {31'd0, irq_model()});
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        if (a == 6'd0) en_m = d;
        if (a == 6'd1) claim_m = 0;
        if (a == 6'd2) fb_m = d;
        if (a >= 6'd16 && a < 6'd32) ctrl_m[a-6'd16] = d[5:0];
        if (a >= 6'd32 && a < 6'd48) hnd_m[a-6'd32] = d;
    endtask

    task automatic rd_reg(input logic [5:0] a, input string req, output logic [31:0] d);
        logic [31:0] exp;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        exp = reg_model(a);
        chk(req, d, exp);
        if (a == 6'd1 && !claim_m && irq_model()) begin
            claim_m = 1; vec_m = exp;
        end
        @(negedge clk);
        bus_sel = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        seed = $urandom(32'd4242);
        rst_n = 0; src_i = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        en_m = '0; fb_m = '0; vec_m = '0; claim_m = 0;
        for (int s = 0; s < NSLOT; s++) begin ctrl_m[s] = '0; hnd_m[s] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        chk_irq("R1 irq after reset");
        rd_reg(6'd0, "R1 enable reset", d);
        rd_reg(6'd2, "R1 fallback reset", d);
        rd_reg(6'd16, "R1 slot ctrl reset", d);
        rd_reg(6'd47, "R1 slot addr reset", d);
        rd_reg(6'd1, "R1 vector reset", d);
        chk("R1 vector zero", d, 32'd0);

        // R11 unmapped word
        wr_reg(6'd5, 32'hFFFF_FFFF);
        rd_reg(6'd5, "R11 unmapped", d);
        chk("R11 unmapped zero", d, 32'd0);

        // R2 R3 R4 programming
        wr_reg(6'd0, 32'h0002_0000);
        rd_reg(6'd0, "R2 enable readback", d);
        wr_reg(6'd17, 32'hFFFF_FF20 | 32'd17);
        rd_reg(6'd17, "R3 ctrl readback", d);
        chk("R3 ctrl masked", d, 32'h0000_0031);
        wr_reg(6'd33, 32'h1000_0170);
        wr_reg(6'd2, 32'hDEAD_0000);
        rd_reg(6'd33, "R4 handler readback", d);
        rd_reg(6'd2, "R4 fallback readback", d);

        // R5 R6 single source
        set_src(32'h0002_0000);
        chk_irq("R5 irq on enabled source");
        #1 chk("R5 irq high", {31'd0, irq_o}, 32'd1);
        rd_reg(6'd1, "R6 vector slot1", d);
        chk("R6 slot1 handler", d, 32'h1000_0170);

        // R8 claim holds across new higher priority source
        chk_irq("R8 irq masked");
        wr_reg(6'd0, 32'h0002_4000);
        wr_reg(6'd16, 32'h20 | 32'd14);
        wr_reg(6'd32, 32'h1000_00E0);
        set_src(32'h0002_4000);
        chk_irq("R8 irq still masked");
        rd_reg(6'd1, "R8 latched vector", d);
        chk("R8 latched value", d, 32'h1000_0170);

        // R9 acknowledge, R7 priority
        wr_reg(6'd1, 32'd0);
        chk_irq("R9 irq after ack");
        rd_reg(6'd1, "R7 lowest slot wins", d);
        chk("R7 slot0 handler", d, 32'h1000_00E0);
        wr_reg(6'd1, 32'd0);

        // R3 disabled slot with matching source is skipped
        wr_reg(6'd16, 32'd14);
        rd_reg(6'd1, "R3 disabled slot skipped", d);
        chk("R3 falls to slot1", d, 32'h1000_0170);
        wr_reg(6'd1, 32'd0);

        // R6 enabled active source with no slot gives fallback
        set_src(32'h0000_4000);
        rd_reg(6'd1, "R6 fallback", d);
        chk("R6 fallback value", d, 32'hDEAD_0000);
        wr_reg(6'd1, 32'd0);

        // R2 source not enabled; R10 idle read does not claim
        set_src(32'h0000_0040);
        chk_irq("R2 disabled source ignored");
        rd_reg(6'd1, "R10 idle read", d);
        set_src(32'h0000_4040);
        chk_irq("R10 irq not blocked");
        #1 chk("R10 irq high", {31'd0, irq_o}, 32'd1);

        // R9 acknowledge while idle has no effect
        wr_reg(6'd1, 32'h1234_5678);
        chk_irq("R9 idle ack no effect");

        // random phase
        for (int it = 0; it < 3000; it++) begin
            int unsigned op;
            logic [5:0] a;
            op = $urandom % 9;
            case (op)
                0: set_src($urandom & $urandom);
                1: wr_reg(6'd0, $urandom | $urandom);
                2: begin
                    a = 6'd16 + 6'($urandom % NSLOT);
                    wr_reg(a, ($urandom % 4 != 0) ? (32'h20 | ($urandom % NSRC)) : $urandom);
                end
                3: wr_reg(6'd32 + 6'($urandom % NSLOT), $urandom);
                4: wr_reg(6'd2, $urandom);
                5, 6: rd_reg(6'd1, "R8 random vector", d);
                7: wr_reg(6'd1, $urandom);
                default: rd_reg(6'($urandom % 64), "R4 random register", d);
            endcase
            chk_irq("R5 random irq");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule